// File: doc/BRIEF.md
# Timed Power-Up Sequencer With Boot Watchdog

This block brings up seven regulator enables in a fixed, timed order after a turn-on event and then checks that the processor has booted. A millisecond tick input paces a small counter. Each rail enable rises once that counter reaches the rail's own delay. The processor reset stays asserted until the latest rail is up. After reset is released, a window of `WIN_MS` ticks runs. The level of the watchdog input on the tick that closes the window decides whether the supplies stay on or the whole tree is shut down.

The controller has five named states, each with a fixed code on `state_o`:
- OFF (0): idle, with every enable low. A turn-on pulse takes it to SEQUENCING.
- SEQUENCING (1): counts ticks. Once the count reaches 18 it moves to WATCHDOG on the next clock.
- WATCHDOG (2): reset is released and the window counts ticks. On the closing tick it moves to ON if the watchdog input is high, or to SHUTDOWN if it is low.
- ON (3): holds every rail. A low watchdog input moves it to SHUTDOWN.
- SHUTDOWN (4): drops every enable and reasserts reset for exactly one cycle, then returns to OFF.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the block is in OFF (`state_o` = 0), all `rail_en` bits are 0 and `cpu_rst_n` is 0.
- R2: In OFF, a high `on_evt` at a clock edge moves the block to SEQUENCING (`state_o` = 1) with the tick count at zero. Without `on_evt` the block stays in OFF, ticks or not.
- R3: In SEQUENCING, only clock edges with `tick_ms` high advance the count. Bit i of `rail_en` is high once the count is at least the rail's delay. The bits and delays are: bit 0 core A at 8, bit 1 core B at 10, bit 2 high-voltage I/O at 12, bit 3 low-voltage I/O at 12, bit 4 memory A at 14, bit 5 memory B at 16, bit 6 PLL/digital at 18. The count stops at 18.
- R4: `rail_en[2]` and `rail_en[3]` always hold the same value.
- R5: `cpu_rst_n` stays 0 throughout SEQUENCING. On the clock edge after the count has reached 18, the block enters WATCHDOG (`state_o` = 2) and `cpu_rst_n` goes to 1, with all rails still on.
- R6: In WATCHDOG, the window ends at the edge of the `WIN_MS`-th tick counted in that state. If `wdog_in` is high at that edge, the block enters ON (`state_o` = 3) with all rails on and reset released.
- R7: If `wdog_in` is low at the window-closing edge, the block enters SHUTDOWN (`state_o` = 4). For that one cycle all rails are 0 and `cpu_rst_n` is 0, and the next edge returns it to OFF.
- R8: `wdog_in` has no effect at any WATCHDOG edge other than the window-closing one.
- R9: `on_evt` has no effect in any state other than OFF.
- R10: In ON, a low `wdog_in` at a clock edge moves the block to SHUTDOWN. A high `wdog_in` keeps it in ON.
- R11: After a return to OFF, a new `on_evt` restarts the whole sequence with the count at zero. A tick that arrives on the same edge as `on_evt` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle enable, once per millisecond |
| on_evt | input | 1 | Turn-on request pulse |
| wdog_in | input | 1 | Watchdog level from the processor |
| rail_en | output | 7 | Regulator enables, bit map as in R3 |
| cpu_rst_n | output | 1 | Processor reset, active low |
| state_o | output | 3 | Controller state code |

## Verification
Some properties are checked by assertions on every cycle:
- a rail never drops except on entry to SHUTDOWN;
- reset released implies every rail is on, and the PLL rail implies all the others;
- SHUTDOWN lasts one cycle;
- WATCHDOG is left only on the window-closing tick;
- both counters stay within their bounds.

Other behaviour only the bench scenarios can show:
- that each rail rises on the exact tick given by its delay, including when ticks are sparse;
- that the closing-tick sample decides ON or SHUTDOWN while toggles earlier in the window are ignored;
- that stray turn-on pulses are ignored;
- that a restart begins again from zero.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF  = 3'd0,
        PS_SEQ  = 3'd1,
        PS_WDOG = 3'd2,
        PS_ON   = 3'd3,
        PS_SHUT = 3'd4
    } pwr_state_e;

    localparam int RAIL_N = 7;

    // Turn-on delay in ticks for each enable bit.
    localparam int RAIL_DLY [RAIL_N] = '{8, 10, 12, 12, 14, 16, 18};

    function automatic int max_delay();
        int m;
        m = 0;
        for (int i = 0; i < RAIL_N; i++) begin
            if (RAIL_DLY[i] > m) m = RAIL_DLY[i];
        end
        return m;
    endfunction

    localparam int SEQ_LAST = max_delay();

endpackage

// File: rtl/pwr_seq_tmr.sv
module pwr_seq_tmr
    import pwr_seq_pkg::*;
#(
    parameter int LAST   = 18,
    parameter int WIN_MS = 500,
    localparam int CNT_W = $clog2(LAST + 1),
    localparam int WIN_W = $clog2(WIN_MS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  pwr_state_e       st,
    output logic [CNT_W-1:0] seq_cnt,
    output logic             seq_done,
    output logic             win_end
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);
    localparam logic [WIN_W-1:0] WEND_V = WIN_W'(WIN_MS - 1);

    logic [WIN_W-1:0] win_cnt;

    assign seq_done = (seq_cnt == LAST_V);
    assign win_end  = (st == PS_WDOG) && tick && (win_cnt == WEND_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_cnt <= '0;
        end else if (st == PS_OFF || st == PS_SHUT) begin
            seq_cnt <= '0;
        end else if (st == PS_SEQ && tick && !seq_done) begin
            seq_cnt <= seq_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (st != PS_WDOG) begin
            win_cnt <= '0;
        end else if (tick && !win_end) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // R3
    seq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cnt <= LAST_V);

    // R6
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WEND_V);

    // R3
    seq_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_SEQ && !tick) |=> $stable(seq_cnt));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_evt,
    input  logic       wdog_in,
    input  logic       seq_done,
    input  logic       win_end,
    output pwr_state_e st_q,
    output logic       rails_live,
    output logic       rst_rel
);

    pwr_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_OFF:  if (on_evt)   st_d = PS_SEQ;
            PS_SEQ:  if (seq_done) st_d = PS_WDOG;
            PS_WDOG: if (win_end)  st_d = wdog_in ? PS_ON : PS_SHUT;
            PS_ON:   if (!wdog_in) st_d = PS_SHUT;
            PS_SHUT:               st_d = PS_OFF;
            default:               st_d = PS_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        rails_live = 1'b0;
        rst_rel    = 1'b0;
        unique case (st_q)
            PS_SEQ:  rails_live = 1'b1;
            PS_WDOG: begin rails_live = 1'b1; rst_rel = 1'b1; end
            PS_ON:   begin rails_live = 1'b1; rst_rel = 1'b1; end
            default: ;
        endcase
    end

    // R7
    shut_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == PS_SHUT |=> st_q == PS_OFF);

    // R10
    on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_ON && wdog_in) |=> st_q == PS_ON);

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_OFF && !on_evt) |=> st_q == PS_OFF);

    // R8
    wdog_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_WDOG && !win_end) |=> st_q == PS_WDOG);

endmodule

// File: rtl/pwr_seq_rails.sv
module pwr_seq_rails
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              shut,
    input  logic [CNT_W-1:0]  cnt,
    output logic [RAIL_N-1:0] en
);

    for (genvar g = 0; g < RAIL_N; g++) begin : g_rail
        localparam logic [CNT_W-1:0] DLY_V = CNT_W'(RAIL_DLY[g]);

        assign en[g] = live && (cnt >= DLY_V);

        // R3
        rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en[g] |=> (en[g] || shut));
    end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int WIN_MS = 500,
    localparam int CNT_W = $clog2(SEQ_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              on_evt,
    input  logic              wdog_in,
    output logic [RAIL_N-1:0] rail_en,
    output logic              cpu_rst_n,
    output logic [2:0]        state_o
);

    pwr_state_e       st;
    logic [CNT_W-1:0] seq_cnt;
    logic             seq_done;
    logic             win_end;
    logic             live;
    logic             rel;

    pwr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_evt     (on_evt),
        .wdog_in    (wdog_in),
        .seq_done   (seq_done),
        .win_end    (win_end),
        .st_q       (st),
        .rails_live (live),
        .rst_rel    (rel)
    );

    pwr_seq_tmr #(.LAST(SEQ_LAST), .WIN_MS(WIN_MS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .st       (st),
        .seq_cnt  (seq_cnt),
        .seq_done (seq_done),
        .win_end  (win_end)
    );

    pwr_seq_rails #(.CNT_W(CNT_W)) u_rails (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .shut  (st == PS_SHUT),
        .cnt   (seq_cnt),
        .en    (rail_en)
    );

    assign cpu_rst_n = rel;
    assign state_o   = st;

    // R5
    rst_after_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |-> (&rail_en));

    // R3
    pll_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[RAIL_N-1] |-> (&rail_en));

    // R4
    io_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[2] == rail_en[3]);

    // R7
    shut_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> (rail_en == '0 && !cpu_rst_n));

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;

    localparam int WIN = 500;
    localparam int NR  = 7;
    localparam int S_OFF = 0, S_SEQ = 1, S_WDOG = 2, S_ON = 3, S_SHUT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic on_evt = 1'b0;
    logic wdog_in = 1'b0;
    logic [NR-1:0] rail_en;
    logic cpu_rst_n;
    logic [2:0] state_o;

    always #4 clk = ~clk;

    pwr_seq_top #(.WIN_MS(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .on_evt(on_evt),
        .wdog_in(wdog_in), .rail_en(rail_en), .cpu_rst_n(cpu_rst_n),
        .state_o(state_o)
    );

    typedef struct {
        logic [NR-1:0] rails;
        logic          rst;
        logic [2:0]    st;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int m_st = S_OFF, m_ticks = 0, m_wt = 0;
    int dly [NR] = '{8, 10, 12, 12, 14, 16, 18};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outcome.
    task automatic cyc(input logic t, input logic on, input logic w, input string tag);
        exp_t e;
        @(negedge clk);
        tick_ms = t; on_evt = on; wdog_in = w;
        case (m_st)
            S_OFF:  if (on) begin m_st = S_SEQ; m_ticks = 0; end
            S_SEQ:  if (m_ticks == 18) begin m_st = S_WDOG; m_wt = 0; end
                    else if (t) m_ticks++;
            S_WDOG: if (t) begin
                        if (m_wt == WIN - 1) m_st = w ? S_ON : S_SHUT;
                        else m_wt++;
                    end
            S_ON:   if (!w) m_st = S_SHUT;
            default: m_st = S_OFF;
        endcase
        for (int i = 0; i < NR; i++)
            e.rails[i] = (m_st == S_SEQ || m_st == S_WDOG || m_st == S_ON) && (m_ticks >= dly[i]);
        e.rst = (m_st == S_WDOG || m_st == S_ON);
        e.st  = 3'(m_st);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(rail_en == e.rails, e.tag, "rail_en", rail_en, e.rails);
                chk(cpu_rst_n == e.rst, e.tag, "cpu_rst_n", cpu_rst_n, e.rst);
                chk(state_o == e.st, e.tag, "state_o", state_o, e.st);
                chk(rail_en[2] == rail_en[3], "R4", "io pair", rail_en[3:2], {2{rail_en[2]}});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(state_o == 3'd0, "R1", "state_o", state_o, 0);
        chk(rail_en == '0, "R1", "rail_en", rail_en, 0);
        chk(cpu_rst_n == 1'b0, "R1", "cpu_rst_n", cpu_rst_n, 0);
        rst_n = 1'b1;

        // R2: ticks without a turn-on pulse keep OFF
        for (int k = 0; k < 4; k++) cyc(1, 0, 1, "R2");
        cyc(0, 1, 0, "R2");

        // R3 sparse ticks, R9 stray pulses, R5 reset release
        for (int k = 0; k < 70; k++) begin
            if (k == 20 || k == 40) cyc(k % 3 == 0, 1, 0, "R9");
            else if (m_st == S_WDOG) cyc(k % 3 == 0, 0, 0, "R5");
            else cyc(k % 3 == 0, 0, 0, "R3");
        end

        // R8 toggling watchdog, R6 high at closing tick
        for (int k = 0; k < 2000 && m_st == S_WDOG; k++) begin
            if (m_wt == WIN - 1) cyc(1, 0, 1, "R6");
            else cyc(1, 0, k % 2, "R8");
        end

        // R9 pulse in ON, R10 drop
        for (int k = 0; k < 5; k++) cyc(k % 2, k == 2, 1, k == 2 ? "R9" : "R10");
        cyc(1, 0, 0, "R10");
        cyc(0, 0, 0, "R7");
        cyc(0, 0, 0, "R7");

        // R11 restart, R5 every-cycle ticks, R7 low at closing tick
        cyc(0, 1, 1, "R11");
        for (int k = 0; k < 2000 && m_st != S_OFF; k++) begin
            if (m_st == S_SEQ) cyc(1, 0, 1, "R5");
            else if (m_st == S_WDOG && m_wt == WIN - 1) cyc(1, 0, 0, "R7");
            else if (m_st == S_WDOG) cyc(1, 0, 1, "R8");
            else cyc(0, 0, 0, "R7");
        end
        cyc(0, 0, 0, "R7");

        // R11 restart with tick on the same edge
        cyc(1, 1, 1, "R11");
        for (int k = 0; k < 30; k++) cyc(1, 0, 1, "R11");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule